// File: doc/BRIEF.md
# Serial Memory Target with Pointer-Based Reads

This block is a two-wire bus target that presents a 512-byte memory to a bus controller. It runs entirely from a faster system clock. SCL and SDA are first passed through synchronizers, and the block then watches their edges. From those edges it recognises START, repeated START and STOP, shifts in the address byte, and answers by pulling SDA low through an open-drain enable.

The block keeps one internal byte pointer, and that pointer is kept from one transaction to the next. A read-addressed frame with no address phase before it returns the byte at the pointer. This is the current-address read. A random read works in two steps: the controller sends a write-addressed frame and a single byte address, which sets the pointer, then sends a repeated START with a read frame. When the controller acknowledges a data byte, the next location follows, and reads wrap from the last location of the array to location 0. Bytes written after the byte address are stored in the array. During a write, the pointer wraps inside its 16-byte page. This write path is there so the contents can be loaded and the pointer set.

Top module: `i2c_mem_target`

## Requirements
- R1: The target answers only when the first byte after a START has bits 7..4 equal to 1010 and bits 3..2 equal to `strap_i`. The byte is sent MSB first, and bit 0 is the R/W flag, with 1 meaning read. On a match, SDA is held low during the 9th clock. Without a match, SDA stays released and all traffic is ignored until the next START, with the pointer unchanged.
- R2: A write frame (R/W = 0) is followed by one byte. The target acknowledges that byte and loads the pointer with bit 1 of the frame as address bit 8 and the byte as bits 7..0.
- R3: Each further byte in a write frame is acknowledged and stored at the pointer. The pointer then steps in its low 4 bits only, so it wraps to the start of the same 16-byte page.
- R4: A read frame that follows a START returns the byte at the pointer as it stands at that moment.
- R5: A write frame with a byte address, followed by a repeated START and a read frame, returns the byte at that address. The dummy write itself changes no array content.
- R6: Read data is driven MSB first while SCL is low, and SDA is released for the 9th clock. If the controller drives SDA low on that clock, the byte at the next location follows.
- R7: During reads the pointer wraps from 511 to 0.
- R8: The pointer steps by one after every byte read, so a later current-address read returns the location after the last byte sent.
- R9: After a NoACK and a STOP, the target returns to idle and keeps SDA released, even if SCL keeps toggling.
- R10: A START or STOP that arrives part-way through a byte abandons that byte and restarts bit counting. A new address frame then works normally.
- R11: The SDA enable changes only while the synchronized SCL is low.
- R12: Reset releases SDA and sets the pointer to 0. Array contents are not reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as received |
| sda_i | input | 1 | Bus data line as received (wired value) |
| strap_i | input | 2 | Board strap compared with address-frame bits 3..2 |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The stimulus targets the places where pointer handling is easy to get wrong. A sequential read runs across location 511, so a design that wraps per page, or that stops counting, returns the wrong bytes right after the wrap. A page write starts near the end of a page and runs past it; a design that carries into the page bits would place the data in the next page. A current-address read follows each read burst, which catches a pointer that misses its step after the final NoACK byte. A read after a dummy write, and frames cut off part-way through, expose stale bit counters and unwanted writes to the array. Mismatched device codes and straps, and SCL pulses after STOP, show up as SDA being pulled when it should be released.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;

    // device-type nibble expected in address-frame bits 7..4
    localparam logic [3:0] DEV_CODE = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,        // shifting in the address frame
        ST_ADDR_ACK,    // driving acknowledge for the address frame
        ST_BADDR,       // shifting in the byte address
        ST_BADDR_ACK,
        ST_WDATA,       // shifting in a byte to store
        ST_WDATA_ACK,
        ST_RDATA,       // driving a data byte
        ST_RACK,        // sampling the controller's acknowledge
        ST_IGNORE       // off the bus until the next START
    } tgt_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    // chain_q[STAGES-1] is the synchronized level, chain_q[STAGES] its previous value
    logic [STAGES:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-1:0], line_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign level_o = chain_q[STAGES-1];
    assign rise_o  =  chain_q[STAGES-1] & ~chain_q[STAGES];
    assign fall_o  = ~chain_q[STAGES-1] &  chain_q[STAGES];
endmodule

// File: rtl/i2c_mem_array.sv
module i2c_mem_array #(
    parameter int DEPTH = 512,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [7:0]    wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [7:0]    rdata_o
);
    logic [7:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) store_q[waddr_i] <= wdata_i;
    end

    assign rdata_o = store_q[raddr_i];
endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target
    import i2c_mem_pkg::*;
#(
    parameter int MEM_BYTES   = 512,
    parameter int PAGE_BYTES  = 16,
    parameter int SYNC_STAGES = 2,
    localparam int AW      = $clog2(MEM_BYTES),
    localparam int PW      = $clog2(PAGE_BYTES),
    localparam int HI_W    = AW - 8,
    localparam int STRAP_W = 3 - HI_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic [STRAP_W-1:0] strap_i,
    output logic               sda_oe_o
);
    typedef struct packed {
        tgt_state_e      st;
        logic [7:0]      sh;     // shift register, MSB on the wire first
        logic [3:0]      cnt;    // bits shifted in / driven out
        logic [AW-1:0]   ptr;
        logic [HI_W-1:0] hi;     // upper address bits taken from the frame
        logic            rw;
        logic            nack;
        logic            oe;
    } tgt_regs_t;

    tgt_regs_t r_d, r_q;

    logic scl_lvl, scl_rise, scl_fall;
    logic sda_lvl, sda_rise, sda_fall;
    logic start_det, stop_det, dev_match;
    logic mem_we;
    logic [7:0] mem_rdata;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .line_i(scl_i),
        .level_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall)
    );

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .line_i(sda_i),
        .level_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall)
    );

    i2c_mem_array #(.DEPTH(MEM_BYTES)) u_array (
        .clk(clk), .we_i(mem_we), .waddr_i(r_q.ptr), .wdata_i(r_q.sh),
        .raddr_i(r_q.ptr), .rdata_o(mem_rdata)
    );

    assign start_det = sda_fall & scl_lvl;
    assign stop_det  = sda_rise & scl_lvl;
    assign dev_match = (r_q.sh[7:4] == DEV_CODE) && (r_q.sh[3:HI_W+1] == strap_i);

    always_comb begin
        r_d    = r_q;
        mem_we = 1'b0;
        if (stop_det) begin
            r_d.st  = ST_IDLE;
            r_d.cnt = '0;
            r_d.oe  = 1'b0;
        end else if (start_det) begin
            r_d.st  = ST_ADDR;
            r_d.cnt = '0;
            r_d.oe  = 1'b0;
        end else begin
            unique case (r_q.st)
                ST_ADDR, ST_BADDR, ST_WDATA: begin
                    if (scl_rise && r_q.cnt < 4'd8) begin
                        r_d.sh  = {r_q.sh[6:0], sda_lvl};
                        r_d.cnt = r_q.cnt + 4'd1;
                    end else if (scl_fall && r_q.cnt == 4'd8) begin
                        r_d.cnt = '0;
                        if (r_q.st == ST_ADDR) begin
                            if (dev_match) begin
                                r_d.oe = 1'b1;
                                r_d.rw = r_q.sh[0];
                                r_d.hi = r_q.sh[HI_W:1];
                                r_d.st = ST_ADDR_ACK;
                            end else begin
                                r_d.st = ST_IGNORE;
                            end
                        end else if (r_q.st == ST_BADDR) begin
                            r_d.ptr = {r_q.hi, r_q.sh};
                            r_d.oe  = 1'b1;
                            r_d.st  = ST_BADDR_ACK;
                        end else begin
                            mem_we = 1'b1;
                            r_d.ptr[PW-1:0] = r_q.ptr[PW-1:0] + 1'b1;
                            r_d.oe  = 1'b1;
                            r_d.st  = ST_WDATA_ACK;
                        end
                    end
                end
                ST_ADDR_ACK, ST_BADDR_ACK, ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        if (r_q.st == ST_ADDR_ACK && r_q.rw) begin
                            r_d.sh  = mem_rdata;
                            r_d.oe  = ~mem_rdata[7];
                            r_d.cnt = 4'd1;
                            r_d.st  = ST_RDATA;
                        end else begin
                            r_d.oe  = 1'b0;
                            r_d.cnt = '0;
                            r_d.st  = (r_q.st == ST_ADDR_ACK) ? ST_BADDR : ST_WDATA;
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (r_q.cnt == 4'd8) begin
                            r_d.oe  = 1'b0;
                            r_d.ptr = r_q.ptr + 1'b1;
                            r_d.st  = ST_RACK;
                        end else begin
                            r_d.sh  = {r_q.sh[6:0], 1'b0};
                            r_d.oe  = ~r_q.sh[6];
                            r_d.cnt = r_q.cnt + 4'd1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        r_d.nack = sda_lvl;
                    end else if (scl_fall) begin
                        if (!r_q.nack) begin
                            r_d.sh  = mem_rdata;
                            r_d.oe  = ~mem_rdata[7];
                            r_d.cnt = 4'd1;
                            r_d.st  = ST_RDATA;
                        end else begin
                            r_d.st  = ST_IGNORE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign sda_oe_o = r_q.oe;
endmodule

// File: rtl/i2c_mem_target_chk.sv
module i2c_mem_target_chk
    import i2c_mem_pkg::*;
#(
    parameter int AW = 9,
    parameter int PW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_lvl,
    input logic          sda_oe,
    input tgt_state_e    st,
    input logic [AW-1:0] ptr
);
    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_lvl); // R11

    AST_QUIET_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE || st == ST_IGNORE) |-> !sda_oe); // R9

    AST_ACK_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ADDR_ACK || st == ST_BADDR_ACK || st == ST_WDATA_ACK) |-> sda_oe); // R1

    AST_RACK_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RACK) |-> !sda_oe); // R6

    AST_READ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st) == ST_RDATA && st == ST_RACK) |-> ptr == AW'($past(ptr) + 1'b1)); // R8

    AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st) == ST_WDATA && st == ST_WDATA_ACK) |-> ptr[AW-1:PW] == $past(ptr[AW-1:PW])); // R3
endmodule

bind i2c_mem_target i2c_mem_target_chk #(.AW(AW), .PW(PW)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_oe(sda_oe_o),
    .st(r_q.st), .ptr(r_q.ptr)
);

// File: tb/test_i2c_mem_target.sv
`timescale 1ns/1ps
module test_i2c_mem_target;
    localparam int Q = 8;                 // system clocks per quarter bit
    localparam logic [1:0] STRAP = 2'b01;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m_low = 1'b0;
    logic sda_oe;
    logic sda_line;

    always #2 clk = ~clk;                 // 250 MHz

    assign sda_line = ~(sda_m_low | sda_oe);

    i2c_mem_target i_i2c_mem_target (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .strap_i(STRAP), .sda_oe_o(sda_oe)
    );

    int nvec = 0;
    int nerr = 0;
    int r11_viol = 0;
    logic [7:0] shadow [512];
    logic [8:0] mptr;
    logic oe_prev = 1'b0;

    task automatic check(input string req, input int act, input int exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R11 monitor: enable may only move while SCL is low
    always @(posedge clk) begin
        #1;
        if (rst_n && sda_oe !== oe_prev && scl_m) r11_viol++;
        oe_prev = sda_oe;
    end

    function automatic logic [7:0] devb(input logic hi, input logic rd);
        return {4'b1010, STRAP, hi, rd};
    endfunction

    function automatic logic [8:0] page_step(input logic [8:0] a);
        return {a[8:4], a[3:0] + 4'd1};
    endfunction

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m_low = 1'b0; scl_m = 1'b1; wq();
        sda_m_low = 1'b1; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_rstart();
        sda_m_low = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m_low = 1'b1; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m_low = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m_low = 1'b0; wq();
    endtask

    task automatic send_bit(input logic b);
        sda_m_low = ~b; wq();
        scl_m = 1'b1; wq(); wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic recv_bit(output logic b);
        sda_m_low = 1'b0; wq();
        scl_m = 1'b1; wq();
        b = sda_line; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(b);
        ack = ~b;
    endtask

    task automatic recv_byte(output logic [7:0] v, input logic ack_m);
        for (int i = 7; i >= 0; i--) recv_bit(v[i]);
        send_bit(~ack_m);
    endtask

    // page write of n bytes starting at addr; shadow and pointer model follow R2/R3
    task automatic mem_write(input logic [8:0] addr, input int n);
        logic ack;
        logic [7:0] v;
        bus_start();
        send_byte(devb(addr[8], 1'b0), ack); check("R1 write frame ack", ack, 1);
        send_byte(addr[7:0], ack);           check("R2 byte address ack", ack, 1);
        mptr = addr;
        for (int i = 0; i < n; i++) begin
            v = 8'($urandom);
            send_byte(v, ack);               check("R3 data ack", ack, 1);
            shadow[mptr] = v;
            mptr = page_step(mptr);
        end
        bus_stop();
    endtask

    task automatic read_burst(input int n, input string tag);
        logic [7:0] v;
        for (int i = 0; i < n; i++) begin
            recv_byte(v, i != n - 1);
            check(tag, v, shadow[mptr]);
            mptr = mptr + 9'd1;
        end
        bus_stop();
    endtask

    task automatic rand_read(input logic [8:0] addr, input int n, input string tag);
        logic ack;
        bus_start();
        send_byte(devb(addr[8], 1'b0), ack); check("R5 dummy frame ack", ack, 1);
        send_byte(addr[7:0], ack);           check("R5 byte address ack", ack, 1);
        mptr = addr;
        bus_rstart();
        send_byte(devb(1'b0, 1'b1), ack);    check("R5 read frame ack", ack, 1);
        read_burst(n, tag);
    endtask

    task automatic cur_read(input int n, input string tag);
        logic ack;
        bus_start();
        send_byte(devb(1'b0, 1'b1), ack);    check("R4 read frame ack", ack, 1);
        read_burst(n, tag);
    endtask

    initial begin
        logic ack;
        logic b;
        logic [8:0] bases [3];
        void'($urandom(32'd20240611));
        bases[0] = 9'h000; bases[1] = 9'h0A0; bases[2] = 9'h1F0;

        repeat (5) @(negedge clk);
        check("R12 SDA released in reset", sda_oe, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // preload three pages; 0x1F0 uses frame bit 1 as address bit 8 (R2)
        mem_write(9'h1F0, 16);
        mem_write(9'h000, 16);
        mem_write(9'h0AE, 20);             // runs past the page end: R3
        cur_read(1, "R3 pointer wrapped inside page");

        // R7: sequential read across the top of the array
        rand_read(9'h1F8, 16, "R7 sequential read across 511");
        cur_read(1, "R8 current read after burst");
        cur_read(2, "R4 current read");

        // R5: dummy write with no data must not store
        bus_start();
        send_byte(devb(1'b0, 1'b0), ack); check("R5 dummy frame ack", ack, 1);
        send_byte(8'h05, ack);            check("R5 byte address ack", ack, 1);
        bus_stop();
        mptr = 9'h005;
        cur_read(1, "R5 dummy write left content");

        // R1: wrong strap and wrong device code
        bus_start();
        send_byte({4'b1010, ~STRAP, 1'b0, 1'b1}, ack); check("R1 wrong strap no ack", ack, 0);
        for (int i = 0; i < 9; i++) begin
            recv_bit(b); check("R1 ignored traffic", b, 1);
        end
        bus_stop();
        bus_start();
        send_byte({4'b1011, STRAP, 1'b0, 1'b0}, ack); check("R1 wrong code no ack", ack, 0);
        send_byte(8'h40, ack);                        check("R1 ignored byte address", ack, 0);
        bus_stop();
        cur_read(1, "R1 pointer unchanged by foreign frames");

        // R9: SCL activity after NACK and STOP
        for (int i = 0; i < 9; i++) begin
            recv_bit(b); check("R9 idle keeps SDA released", b, 1);
        end
        sda_m_low = 1'b0; scl_m = 1'b1; wq();

        // R10: START and STOP part-way through a byte
        bus_start();
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        bus_rstart();
        send_byte(devb(1'b0, 1'b1), ack); check("R10 frame after mid-byte START", ack, 1);
        read_burst(1, "R10 data after mid-byte START");
        bus_start();
        for (int i = 0; i < 3; i++) send_bit(1'b0);
        bus_stop();
        cur_read(1, "R10 data after mid-byte STOP");

        // R12: reset clears pointer, keeps array
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check("R12 SDA released in reset", sda_oe, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        mptr = 9'h000;
        cur_read(1, "R12 pointer zero after reset");

        // random random-reads inside the preloaded pages (R6)
        for (int k = 0; k < 24; k++) begin
            logic [8:0] a;
            int n;
            a = bases[$urandom % 3] + 9'($urandom % 14);
            n = 1 + int'($urandom % 3);
            rand_read(a, n, "R6 random read data");
        end

        check("R11 enable moved with SCL high", r11_viol, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        nvec++;
        nerr++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule